// File: doc/BRIEF.md
# JTAG Port Steering by Strap Capture

This block decides which of two test access ports the external JTAG pins reach after a test reset. There are two candidates: the on-chip debug port and the boundary scan port. Two strap pins choose between them, and each strap pin sits behind a pad function multiplexer with a 4-bit function field.

When the active-low test reset is released, the block captures the two strap values as the core sees them. The captured code then steers the port for as long as test reset stays high. Strap B can be given to a probe clock output instead. When a pad is taken for another function, its multiplexer forces a fixed level into the capture path. So repurposing a pin can silently put the port into boundary scan. The block reproduces that behaviour faithfully, so that integration can be checked against it.

The test reset input is assumed to be already synchronous to `clk`. The captured state lives in `clk` registers with a synchronous active-high reset. Port routing is combinational from the registered selection.

Top module: `jtag_tap_steer`

## Requirements
- R1: Strap A reaches the core as the pad level when its function field is 0 or 15. Every other function value forces the core value to 0.
- R2: Strap B reaches the core as the pad level only when its function field is 0. Every other function value forces the core value to 0.
- R3: At the first clock edge where `test_rst_n` is sampled high after being sampled low, `strap_code` loads the core strap values. Bit 1 holds strap B and bit 0 holds strap A. The new value is visible after that edge.
- R4: A captured code of 2'b01 sets `tap_sel` to 1 (boundary scan). Any other captured code sets `tap_sel` to 0 (debug port).
- R5: While `test_rst_n` is sampled low, `tap_sel` and `strap_code` are 0 after each edge. Both port reset outputs follow `test_rst_n` low.
- R6: While `test_rst_n` stays high, changes to the function fields or the pad levels leave `tap_sel` and `strap_code` unchanged.
- R7: The selected port receives `tms`, and the unselected port receives `tms` held at 1. Both ports receive `tdi`. `tdo` comes from the selected port only.
- R8: When strap B's function field equals the probe mode (default 1), `strap_b_oe` is 1 from the next edge and `strap_b_out` follows `probe_clk`. Otherwise `strap_b_oe` is 0 and `strap_b_out` is 0.
- R9: During and after `rst`, `tap_sel`, `strap_code` and `strap_b_oe` are 0. No capture happens until `test_rst_n` has been sampled low and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| test_rst_n | input | 1 | Active-low test reset from the JTAG port |
| tms | input | 1 | Port mode select |
| tdi | input | 1 | Port data in |
| tdo | output | 1 | Port data out, taken from the selected port |
| strap_a_func | input | 4 | Strap A pad function field |
| strap_b_func | input | 4 | Strap B pad function field |
| strap_a_pad | input | 1 | Strap A pad level (pulled high when undriven) |
| strap_b_pad | input | 1 | Strap B pad level |
| probe_clk | input | 1 | Clock to drive out on the strap B pad |
| strap_b_out | output | 1 | Strap B pad output value |
| strap_b_oe | output | 1 | Strap B pad output enable |
| dbg_tdo | input | 1 | Data out of the debug port |
| bs_tdo | input | 1 | Data out of the boundary scan port |
| dbg_tms | output | 1 | Mode select to the debug port |
| dbg_tdi | output | 1 | Data in to the debug port |
| dbg_trst_n | output | 1 | Reset to the debug port |
| bs_tms | output | 1 | Mode select to the boundary scan port |
| bs_tdi | output | 1 | Data in to the boundary scan port |
| bs_trst_n | output | 1 | Reset to the boundary scan port |
| tap_sel | output | 1 | 1 = boundary scan selected, 0 = debug port |
| strap_code | output | 2 | Captured strap code {B, A} |

## Verification
The captured code and selection change on the rising edge where `test_rst_n` is first seen high. `strap_b_oe` changes on the rising edge after the function field changes. Routing and the port resets are combinational and follow the inputs within the same cycle. The bench drives inputs 2 ns after each rising edge and compares every output at the falling edge against a behavioural model. The model updates its registered state at the rising edge, so every registered result is compared half a cycle after the edge that produced it, and every combinational result is compared in the cycle its inputs changed.

// File: rtl/jtag_tap_steer_pkg.sv
package jtag_tap_steer_pkg;
  localparam int FUNC_W = 4;
  localparam int CODE_W = 2;

  typedef enum logic {
    SEL_DEBUG = 1'b0,
    SEL_BSCAN = 1'b1
  } tap_sel_e;
endpackage

// File: rtl/strap_pad_mux.sv
module strap_pad_mux #(
  parameter int FUNC_W = 4,
  parameter logic [FUNC_W-1:0] PASS_FUNC = '0,
  parameter bit ALT_PASS_EN = 1'b0,
  parameter logic [FUNC_W-1:0] ALT_FUNC = '1
) (
  input  logic [FUNC_W-1:0] pad_func,
  input  logic              pad_in,
  output logic              core_val
);
  logic pass;

  generate
    if (ALT_PASS_EN) begin : g_alt
      // R1: a second function value also presents the pad level
      assign pass = (pad_func == PASS_FUNC) || (pad_func == ALT_FUNC);
    end else begin : g_single
      // R2: only the emulation function presents the pad level
      assign pass = (pad_func == PASS_FUNC);
    end
  endgenerate

  assign core_val = pass ? pad_in : 1'b0;
endmodule

// File: rtl/probe_pad_drv.sv
module probe_pad_drv #(
  parameter int FUNC_W = 4,
  parameter logic [FUNC_W-1:0] PROBE_FUNC = 4'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FUNC_W-1:0] pad_func,
  input  logic              probe_clk,
  output logic              pad_out,
  output logic              pad_oe
);
  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= (pad_func == PROBE_FUNC);
  end

  assign pad_oe  = oe_q;
  assign pad_out = oe_q & probe_clk;

  // R8
  probe_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_func == PROBE_FUNC) |=> pad_oe);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import jtag_tap_steer_pkg::*;
#(
  parameter int W = CODE_W,
  parameter logic [W-1:0] BSCAN_CODE = 2'b01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_rst_n,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code_q,
  output tap_sel_e     sel_q
);
  logic trst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trst_q <= 1'b1;
      code_q <= '0;
      sel_q  <= SEL_DEBUG;
    end else begin
      trst_q <= test_rst_n;
      if (!test_rst_n) begin
        code_q <= '0;
        sel_q  <= SEL_DEBUG;
      end else if (!trst_q) begin
        code_q <= code_in;
        sel_q  <= (code_in == BSCAN_CODE) ? SEL_BSCAN : SEL_DEBUG;
      end
    end
  end

  // R5
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    !test_rst_n |=> (sel_q == SEL_DEBUG && code_q == '0));

  // R6
  hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (test_rst_n && trst_q) |=> ($stable(code_q) && $stable(sel_q)));

  // R4
  code_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_BSCAN) == (code_q == BSCAN_CODE));
endmodule

// File: rtl/tap_router.sv
module tap_router
  import jtag_tap_steer_pkg::*;
(
  input  tap_sel_e sel,
  input  logic     test_rst_n,
  input  logic     tms,
  input  logic     tdi,
  input  logic     dbg_tdo,
  input  logic     bs_tdo,
  output logic     tdo,
  output logic     dbg_tms,
  output logic     dbg_tdi,
  output logic     dbg_trst_n,
  output logic     bs_tms,
  output logic     bs_tdi,
  output logic     bs_trst_n
);
  always_comb begin
    dbg_tms = 1'b1;
    bs_tms  = 1'b1;
    tdo     = dbg_tdo;
    if (sel == SEL_BSCAN) begin
      bs_tms = tms;
      tdo    = bs_tdo;
    end else begin
      dbg_tms = tms;
    end
  end

  assign dbg_tdi    = tdi;
  assign bs_tdi     = tdi;
  assign dbg_trst_n = test_rst_n;
  assign bs_trst_n  = test_rst_n;
endmodule

// File: rtl/jtag_tap_steer.sv
module jtag_tap_steer
  import jtag_tap_steer_pkg::*;
#(
  parameter logic [FUNC_W-1:0] STRAP_FUNC = 4'd0,
  parameter logic [FUNC_W-1:0] PULL_FUNC  = 4'd15,
  parameter logic [FUNC_W-1:0] PROBE_FUNC = 4'd1,
  parameter logic [CODE_W-1:0] BSCAN_CODE = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_rst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic [FUNC_W-1:0] strap_a_func,
  input  logic [FUNC_W-1:0] strap_b_func,
  input  logic              strap_a_pad,
  input  logic              strap_b_pad,
  input  logic              probe_clk,
  output logic              strap_b_out,
  output logic              strap_b_oe,
  input  logic              dbg_tdo,
  input  logic              bs_tdo,
  output logic              dbg_tms,
  output logic              dbg_tdi,
  output logic              dbg_trst_n,
  output logic              bs_tms,
  output logic              bs_tdi,
  output logic              bs_trst_n,
  output logic              tap_sel,
  output logic [CODE_W-1:0] strap_code
);
  logic              core_a, core_b;
  logic [CODE_W-1:0] code_q;
  tap_sel_e          sel_q;

  strap_pad_mux #(
    .FUNC_W(FUNC_W), .PASS_FUNC(STRAP_FUNC),
    .ALT_PASS_EN(1'b1), .ALT_FUNC(PULL_FUNC)
  ) u_mux_a (
    .pad_func(strap_a_func), .pad_in(strap_a_pad), .core_val(core_a)
  );

  strap_pad_mux #(
    .FUNC_W(FUNC_W), .PASS_FUNC(STRAP_FUNC),
    .ALT_PASS_EN(1'b0), .ALT_FUNC(PULL_FUNC)
  ) u_mux_b (
    .pad_func(strap_b_func), .pad_in(strap_b_pad), .core_val(core_b)
  );

  probe_pad_drv #(.FUNC_W(FUNC_W), .PROBE_FUNC(PROBE_FUNC)) u_probe (
    .clk(clk), .rst(rst), .pad_func(strap_b_func), .probe_clk(probe_clk),
    .pad_out(strap_b_out), .pad_oe(strap_b_oe)
  );

  strap_capture #(.W(CODE_W), .BSCAN_CODE(BSCAN_CODE)) u_cap (
    .clk(clk), .rst(rst), .test_rst_n(test_rst_n),
    .code_in({core_b, core_a}), .code_q(code_q), .sel_q(sel_q)
  );

  tap_router u_route (
    .sel(sel_q), .test_rst_n(test_rst_n), .tms(tms), .tdi(tdi),
    .dbg_tdo(dbg_tdo), .bs_tdo(bs_tdo), .tdo(tdo),
    .dbg_tms(dbg_tms), .dbg_tdi(dbg_tdi), .dbg_trst_n(dbg_trst_n),
    .bs_tms(bs_tms), .bs_tdi(bs_tdi), .bs_trst_n(bs_trst_n)
  );

  assign tap_sel    = (sel_q == SEL_BSCAN);
  assign strap_code = code_q;

  // R7
  idle_tms_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_sel ? dbg_tms : bs_tms));
endmodule

// File: tb/jtag_tap_steer_bench.sv
`timescale 1ns/1ps
module jtag_tap_steer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, test_rst_n = 1'b1, tms = 1'b0, tdi = 1'b0;
  logic [3:0] a_func = 4'd0, b_func = 4'd0;
  logic       a_pad = 1'b1, b_pad = 1'b1, probe_clk = 1'b0;
  logic       dbg_tdo = 1'b0, bs_tdo = 1'b0;
  logic       tdo, b_out, b_oe, dbg_tms, dbg_tdi, dbg_trst_n;
  logic       bs_tms, bs_tdi, bs_trst_n, tap_sel;
  logic [1:0] strap_code;

  jtag_tap_steer u_jtag_tap_steer (
    .clk(clk), .rst(rst), .test_rst_n(test_rst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .strap_a_func(a_func), .strap_b_func(b_func),
    .strap_a_pad(a_pad), .strap_b_pad(b_pad), .probe_clk(probe_clk),
    .strap_b_out(b_out), .strap_b_oe(b_oe), .dbg_tdo(dbg_tdo),
    .bs_tdo(bs_tdo), .dbg_tms(dbg_tms), .dbg_tdi(dbg_tdi),
    .dbg_trst_n(dbg_trst_n), .bs_tms(bs_tms), .bs_tdi(bs_tdi),
    .bs_trst_n(bs_trst_n), .tap_sel(tap_sel), .strap_code(strap_code)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  string phase = "R9";

  // behavioural reference state
  bit       started = 0;
  bit       m_prev = 1, m_sel = 0, m_oe = 0;
  bit [1:0] m_code = 0;

  always @(posedge clk) begin
    bit ca, cb;
    if (rst) begin
      started = 1; m_prev = 1; m_code = 0; m_sel = 0; m_oe = 0;
    end else begin
      ca = (a_func == 4'd0 || a_func == 4'd15) ? a_pad : 1'b0; // R1
      cb = (b_func == 4'd0) ? b_pad : 1'b0;                    // R2
      if (!test_rst_n) begin m_code = 0; m_sel = 0; end
      else if (!m_prev) begin m_code = {cb, ca}; m_sel = (m_code == 2'b01); end
      m_prev = test_rst_n;
      m_oe = (b_func == 4'd1);
    end
  end

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [phase %s] t=%0t actual=%b expected=%b", what, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(strap_code, m_code, "R3 strap_code");
      chk({1'b0, tap_sel}, {1'b0, m_sel}, "R4 tap_sel");
      chk({dbg_trst_n, bs_trst_n}, {test_rst_n, test_rst_n}, "R5 port resets");
      chk({dbg_tms, bs_tms}, m_sel ? {1'b1, tms} : {tms, 1'b1}, "R7 tms");
      chk({dbg_tdi, bs_tdi}, {tdi, tdi}, "R7 tdi");
      chk({1'b0, tdo}, {1'b0, m_sel ? bs_tdo : dbg_tdo}, "R7 tdo");
      chk({b_oe, b_out}, {m_oe, m_oe & probe_clk}, "R8 probe pad");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      tms = ~tms; tdi = $urandom_range(0, 1); probe_clk = ~probe_clk;
      dbg_tdo = $urandom_range(0, 1); bs_tdo = $urandom_range(0, 1);
    end
  endtask

  task automatic session(input string tag, input logic [3:0] fa, input logic pa,
                         input logic [3:0] fb, input logic pb);
    phase = tag;
    @(posedge clk); #2 test_rst_n = 1'b0;
    a_func = fa; a_pad = pa; b_func = fb; b_pad = pb;
    step(3);
    @(posedge clk); #2 test_rst_n = 1'b1;
    step(6);
  endtask

  initial begin
    // R9: reset with test reset high, then no capture without a low pulse
    step(4);
    @(posedge clk); #2 rst = 1'b0;
    step(5);
    session("R3", 4'd0, 1'b1, 4'd0, 1'b1);   // code 11, debug
    session("R2", 4'd0, 1'b1, 4'd1, 1'b1);   // B repurposed: code 01, boundary scan, probe out
    phase = "R6";                             // change everything while test reset high
    a_func = 4'd7; b_func = 4'd0; b_pad = 1'b1; a_pad = 1'b0;
    step(6);
    session("R1", 4'd7, 1'b1, 4'd1, 1'b1);   // A forced 0: code 00, debug
    session("R1", 4'd15, 1'b1, 4'd0, 1'b0);  // A alt pass: code 01
    session("R1", 4'd15, 1'b0, 4'd3, 1'b1);  // code 00
    session("R4", 4'd0, 1'b0, 4'd0, 1'b1);   // code 10, debug
    phase = "R5";
    @(posedge clk); #2 test_rst_n = 1'b0;
    step(4);
    for (int k = 0; k < 60; k++) begin
      phase = "R6";
      @(posedge clk); #2;
      a_func = $urandom_range(0, 15); b_func = $urandom_range(0, 3);
      a_pad = $urandom_range(0, 1); b_pad = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) test_rst_n = ~test_rst_n;
      step(2);
    end
    phase = "R9";
    @(posedge clk); #2 rst = 1'b1;
    step(3);
    @(posedge clk); #2 rst = 1'b0;
    step(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule